// File: doc/BRIEF.md
# Reloadable Down-Counting Timer

This block is a down-counting timer with three registers on a small register bus: a mode register, a count register and a reload register. When the timer is enabled, the count decreases by one on each tick. Ticks come from a prescaler that divides the bus clock by 1, 2, 4 or 8. When the count reaches zero the block gives a one-cycle terminal pulse. If auto-reload is set, the next tick copies the reload value into the count. If it is not set, the timer clears its own enable bit and stops at zero.

Each bus access carries a privilege flag. The mode register has a lock bit. While the lock is set, a user-mode write to the mode register is dropped and a one-cycle fault pulse is raised. A bus access that lands in the same cycle as a decrement or a reload has a fixed outcome:

- A read of the count returns the value before that cycle's decrement.
- A count written while a tick occurs is decremented at once.
- During a reload cycle, a write to the reload register also goes into the count.
- During a reload cycle, a read of the reload register returns the count being loaded.

Top module: `dtimer_unit`

## Requirements
- R1: After synchronous reset, every register reads zero and both `tc_pulse` and `fault_pulse` are low.
- R2: Address 0 is the mode register, with bit 0 = enable, bit 1 = auto-reload, bit 3 = lock and bits 5:4 = clock select. The select code s gives one tick every 2^s bus clocks (00 = 1, 01 = 2, 10 = 4, 11 = 8). After an accepted mode write that enables the timer with count n > 0, `tc_pulse` is first seen n·2^s clock edges after the write edge.
- R3: Every accepted mode write restarts the prescaler phase. No tick occurs in the write cycle, and the first tick follows exactly 2^s edges later.
- R4: Read data is registered. The register addressed (0 mode, 1 count, 2 reload, 3 reads zero) appears on `bus_rdata` after the next edge. A count read returns the count as it was before that cycle's decrement.
- R5: A count write (address 1) in a cycle with a tick loads the written value minus one.
- R6: `tc_pulse` is high for exactly the one cycle after the edge at which the count steps from one to zero.
- R7: Without auto-reload, the edge that brings the count to zero also clears the enable bit. The count then stays at zero.
- R8: With auto-reload, the tick after zero loads the reload value (address 2). Terminal pulses then repeat every (R+1)·2^s edges.
- R9: In a reload cycle, a reload write stores the written data in both the reload and count registers. A reload read in that cycle returns the new count.
- R10: While the lock bit is set, a user write (`bus_user` = 1) to the mode register leaves lock, select, auto-reload and the written enable unapplied, and `fault_pulse` is high for one cycle. Supervisor mode writes, user mode writes while unlocked, and user writes to other registers are all accepted with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | CNT_W | Write data |
| bus_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| bus_rdata | output | CNT_W | Registered read data |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| fault_pulse | output | 1 | One-cycle blocked-write fault |

## Verification
The bench builds the block with `CNT_W` = 8. At that width, start counts, reload values and cycle positions are small enough to compute by hand. With this setting, all four clock-select codes can be swept against ten start counts each, and every terminal-pulse position is predicted as count times divider. The narrow counter also keeps the reload-cycle collision, the prescaler restart and the lock cases within a few dozen cycles each, so each can be placed at an exact edge.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    localparam int SEL_W    = 2;
    localparam int PRE_W    = (1 << SEL_W) - 1;
    localparam int BIT_EN   = 0;
    localparam int BIT_AR   = 1;
    localparam int BIT_LOCK = 3;
    localparam int BIT_CSEL = 4;
    localparam int MODE_W   = BIT_CSEL + SEL_W;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] csel;
        logic             lock;
        logic             ar;
        logic             en;
    } mode_t;

    // Low bits of the phase counter that must all be ones for a tick.
    function automatic logic [PRE_W-1:0] phase_mask(logic [SEL_W-1:0] sel);
        return PRE_W'((1 << sel) - 1);
    endfunction

endpackage

// File: rtl/dtimer_prescaler.sv
module dtimer_prescaler
    import dtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] csel_i,
    output logic             hit_o
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    assign mask  = phase_mask(csel_i);
    assign hit_o = !clear_i && ((phase_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clear_i) phase_q <= '0;
        else                phase_q <= phase_q + PRE_W'(1);
    end

    // R2: with a divider above one, two hits never fall on adjacent cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (!hit_o || csel_i == '0));

endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             ar_i,
    input  logic             cnt_wr_i,
    input  logic             rld_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_next_o,
    output logic             xfer_o,
    output logic             stop_o,
    output logic             tc_o
);

    logic [CNT_W-1:0] count_q, reload_q, base, rld_eff;
    logic             tc_q;
    logic             base_zero, base_one;

    assign base      = cnt_wr_i ? wdata_i : count_q;
    assign rld_eff   = rld_wr_i ? wdata_i : reload_q;
    assign base_zero = (base == '0);
    assign base_one  = (base == CNT_W'(1));
    assign xfer_o    = tick_i && base_zero && ar_i;
    assign stop_o    = tick_i && !ar_i && (base_zero || base_one);

    always_comb begin
        count_next_o = base;
        if (tick_i) begin
            if (!base_zero) count_next_o = base - CNT_W'(1);
            else if (ar_i)  count_next_o = rld_eff;
            else            count_next_o = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            tc_q     <= 1'b0;
        end else begin
            count_q  <= count_next_o;
            reload_q <= rld_eff;
            tc_q     <= tick_i && base_one;
        end
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign tc_o     = tc_q;

    // R6: the terminal pulse is only ever seen alongside a zero count
    a_r6_tc_at_zero: assert property (@(posedge clk) disable iff (rst)
        tc_q |-> (count_q == '0));

    // R9: a reload cycle leaves count and reload equal afterwards
    a_r9_xfer_match: assert property (@(posedge clk) disable iff (rst)
        xfer_o |=> (count_q == reload_q));

endmodule

// File: rtl/dtimer_unit.sv
module dtimer_unit
    import dtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             bus_user,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             tc_pulse,
    output logic             fault_pulse
);

    reg_sel_e         sel;
    mode_t            mode_q;
    logic             mode_hit, mode_ok, blocked, hit, tick;
    logic             stop, xfer, fault_q;
    logic [CNT_W-1:0] count, reload, count_next, rd_mux, rdata_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign mode_hit = bus_wr && (sel == REG_MODE);
    assign blocked  = mode_hit && bus_user && mode_q.lock;
    assign mode_ok  = mode_hit && !blocked;
    assign tick     = mode_q.en && hit;

    dtimer_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear_i (mode_ok),
        .csel_i  (mode_q.csel),
        .hit_o   (hit)
    );

    dtimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .ar_i         (mode_q.ar),
        .cnt_wr_i     (bus_wr && (sel == REG_COUNT)),
        .rld_wr_i     (bus_wr && (sel == REG_RELOAD)),
        .wdata_i      (bus_wdata),
        .count_o      (count),
        .reload_o     (reload),
        .count_next_o (count_next),
        .xfer_o       (xfer),
        .stop_o       (stop),
        .tc_o         (tc_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= blocked;
            if (mode_ok) begin
                mode_q.en   <= bus_wdata[BIT_EN];
                mode_q.ar   <= bus_wdata[BIT_AR];
                mode_q.lock <= bus_wdata[BIT_LOCK];
                mode_q.csel <= bus_wdata[BIT_CSEL +: SEL_W];
            end else if (stop) begin
                mode_q.en   <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_MODE: begin
                rd_mux[BIT_EN]              = mode_q.en;
                rd_mux[BIT_AR]              = mode_q.ar;
                rd_mux[BIT_LOCK]            = mode_q.lock;
                rd_mux[BIT_CSEL +: SEL_W]   = mode_q.csel;
            end
            REG_COUNT:  rd_mux = count;
            REG_RELOAD: rd_mux = xfer ? count_next : reload;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_mux;
    end

    assign bus_rdata   = rdata_q;
    assign fault_pulse = fault_q;

    initial begin
        a_r2_width: assert (CNT_W >= MODE_W);
    end

    // R7: a terminal pulse without auto-reload leaves the timer disabled
    a_r7_stop_on_zero: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && !mode_q.ar) |-> !mode_q.en);

    // R10: a faulting write changes neither lock nor clock select
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> ($stable(mode_q.lock) && $stable(mode_q.csel)));

endmodule

// File: tb/dtimer_unit_bench.sv
module dtimer_unit_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_user = 1'b0;
    logic [W-1:0] bus_rdata;
    logic         tc_pulse, fault_pulse;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dtimer_unit #(.CNT_W(W)) u_dtimer_unit (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_user    (bus_user),
        .bus_rdata   (bus_rdata),
        .tc_pulse    (tc_pulse),
        .fault_pulse (fault_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d, input logic u);
        bus_addr  = a;
        bus_wdata = W'(d);
        bus_user  = u;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
        bus_user  = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        step();
        v = int'(bus_rdata);
    endtask

    task automatic wait_tc(input int limit, output int j);
        j = 0;
        do begin
            step();
            j++;
        end while (!tc_pulse && j < limit);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int v, j, k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(tc_pulse == 1'b0, "R1", "tc after reset", int'(tc_pulse), 0);
        check(fault_pulse == 1'b0, "R1", "fault after reset", int'(fault_pulse), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1", "register after reset", v, 0);
        end

        // R2 / R6 / R7 sweep over every select code and small counts
        for (int d = 0; d < 4; d++) begin
            for (int n = 1; n <= 10; n++) begin
                wr(2'd0, 0, 1'b0);
                wr(2'd1, n, 1'b0);
                wr(2'd0, 1 | (d << 4), 1'b0);
                wait_tc(200, j);
                check(j == n * (1 << d), "R2", "edges to terminal pulse", j, n * (1 << d));
                step();
                check(tc_pulse == 1'b0, "R6", "pulse width", int'(tc_pulse), 0);
                rd(2'd0, v);
                check(v == (d << 4), "R7", "mode after stop", v, d << 4);
                rd(2'd1, v);
                check(v == 0, "R7", "count held at zero", v, 0);
            end
        end

        // R3 prescaler restart on mode write
        wr(2'd0, 0, 1'b0);
        wr(2'd1, 4, 1'b0);
        wr(2'd0, 1 | (3 << 4), 1'b0);
        repeat (5) step();
        wr(2'd0, 1 | (3 << 4), 1'b0);
        wait_tc(200, j);
        check(j == 32, "R3", "edges after rewrite", j, 32);

        // R4 pre-decrement reads, R5 write decremented in the same cycle
        wr(2'd0, 0, 1'b0);
        wr(2'd1, 20, 1'b0);
        wr(2'd0, 1, 1'b0);
        bus_addr = 2'd1;
        for (int i = 1; i <= 10; i++) begin
            step();
            check(int'(bus_rdata) == 21 - i, "R4", "running count read",
                  int'(bus_rdata), 21 - i);
        end
        wr(2'd1, 50, 1'b0);
        rd(2'd1, v);
        check(v == 49, "R5", "written count after tick", v, 49);
        rd(2'd3, v);
        check(v == 0, "R4", "unused address", v, 0);

        // R8 auto-reload period
        wr(2'd0, 0, 1'b0);
        wr(2'd2, 3, 1'b0);
        wr(2'd1, 2, 1'b0);
        wr(2'd0, 1 | 2 | (1 << 4), 1'b0);
        wait_tc(200, j);
        check(j == 4, "R8", "first pulse", j, 4);
        wait_tc(200, k);
        check(k == 8, "R8", "reload period", k, 8);
        rd(2'd0, v);
        check(v == (1 | 2 | (1 << 4)), "R8", "enable kept", v, 1 | 2 | (1 << 4));

        // R9 reload write and read in the transfer cycle
        wr(2'd0, 0, 1'b0);
        wr(2'd2, 5, 1'b0);
        wr(2'd1, 2, 1'b0);
        wr(2'd0, 1 | 2, 1'b0);
        step();
        step();
        wr(2'd2, 9, 1'b0);
        check(int'(bus_rdata) == 9, "R9", "reload read in transfer", int'(bus_rdata), 9);
        rd(2'd1, v);
        check(v == 9, "R9", "count took written reload", v, 9);
        wr(2'd0, 0, 1'b0);
        rd(2'd2, v);
        check(v == 9, "R9", "reload stored", v, 9);

        // R10 supervisor lock
        wr(2'd0, 8, 1'b0);
        check(fault_pulse == 1'b0, "R10", "supervisor write fault", int'(fault_pulse), 0);
        wr(2'd0, 1, 1'b1);
        check(fault_pulse == 1'b1, "R10", "blocked write fault", int'(fault_pulse), 1);
        step();
        check(fault_pulse == 1'b0, "R10", "fault width", int'(fault_pulse), 0);
        rd(2'd0, v);
        check(v == 8, "R10", "mode unchanged", v, 8);
        wr(2'd1, 7, 1'b1);
        check(fault_pulse == 1'b0, "R10", "user count write fault", int'(fault_pulse), 0);
        rd(2'd1, v);
        check(v == 7, "R10", "user count write", v, 7);
        wr(2'd0, 0, 1'b0);
        wr(2'd0, 2, 1'b1);
        check(fault_pulse == 1'b0, "R10", "unlocked user write fault", int'(fault_pulse), 0);
        rd(2'd0, v);
        check(v == 2, "R10", "unlocked user write", v, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule